// File: doc/BRIEF.md
# SRAM Power-Up Response Qualifier

This block judges whether a region of on-chip SRAM is fit to serve as a physical unclonable function. It takes the region's power-up contents as a serial stream of response bits, one bit per accepted beat, and produces simple counting statistics. Those statistics are the number of ones (the fractional weight is this count over the region size), the number of positions where a later readout differs from a stored reference readout (the intra-device distance), and, for each of several programmable lags, how many bit pairs one lag apart agree (the autocorrelation). Each count is compared against a programmable inclusive window, and a single pass flag sums up the verdict.

A session starts with a beat marked first and ends with a beat marked last. On the first beat a kind bit selects the session type. A reference session writes the bits into an internal buffer sized to the region, and counts weight and lagged agreement. A compare session reads the buffer at the same index, counts differing bits and weight, and leaves the buffer untouched. The results, the kind and the pass flag are valid from the cycle after the last beat and hold until the next first beat is accepted.

The input is a valid/ready stream. The block never applies back-pressure: `in_ready` is low only while reset is applied and during the first clock after it is released, and is high from then on. The sender may pause at any time by holding `in_valid` low. A beat is transferred on a rising clock edge where `in_valid` and `in_ready` are both high.

Top module: `puf_stat_analyzer`

## Requirements
- R1: After reset, `in_ready` is 1, `res_valid` and `pass` are 0, and `bit_cnt` and `weight_cnt` are 0.
- R2: `weight_cnt` equals the number of 1 bits among the accepted in-region bits of the session, for both session kinds.
- R3: In a compare session (`in_cmp`=1 on the first beat), `hd_cnt` counts the in-region positions i whose bit differs from bit i of the last reference session. A compare session does not change the stored reference.
- R4: In a reference session (`in_cmp`=0), lag counter k (lag `lag_cfg[k*CNT_W +: CNT_W]`) counts the in-region positions j with j >= lag where bit j equals bit j-lag. Lag 0 counts every in-region bit. A lag at or above the region size gives 0. In a compare session every lag count is 0.
- R5: A beat with `in_first`=1 starts a new session and clears all counts, even in the middle of a session. Beats after `REGION_BITS` in-region bits are not counted, and `bit_cnt` stops at `REGION_BITS`; a later last beat still ends the session. Beats outside a session, other than a first beat, are ignored.
- R6: `res_valid` rises in the cycle after the last beat is accepted. It stays high with all counts unchanged until a first beat is accepted, and drops in the cycle after that beat.
- R7: `wt_ok`, `hd_ok` and `ac_ok[k]` are 1 exactly when the held count lies in its inclusive window [lo, hi]. The window inputs act combinationally on these flags.
- R8: `pass` is 1 only when `res_valid` is 1, `bit_cnt` equals `REGION_BITS` and `wt_ok` is 1, together with all `ac_ok` bits for a reference session or with `hd_ok` for a compare session.
- R9: `res_cmp` reports the kind bit taken from the session's first beat (0 reference, 1 compare).
- R10: Cycles with `in_valid`=0 change no count and no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Response beat valid |
| in_ready | output | 1 | Beat accepted when high with in_valid |
| in_bit | input | 1 | Response bit |
| in_first | input | 1 | Beat opens a session |
| in_last | input | 1 | Beat closes the session |
| in_cmp | input | 1 | Session kind on first beat: 0 reference, 1 compare |
| lag_cfg | input | NUM_LAGS*CNT_W | Packed autocorrelation lags |
| wt_lo | input | CNT_W | Weight window low bound |
| wt_hi | input | CNT_W | Weight window high bound |
| hd_lo | input | CNT_W | Distance window low bound |
| hd_hi | input | CNT_W | Distance window high bound |
| ac_lo | input | NUM_LAGS*CNT_W | Packed per-lag agreement low bounds |
| ac_hi | input | NUM_LAGS*CNT_W | Packed per-lag agreement high bounds |
| res_valid | output | 1 | Results valid |
| res_cmp | output | 1 | Kind of the reported session |
| bit_cnt | output | CNT_W | In-region bits counted |
| weight_cnt | output | CNT_W | Ones counted |
| hd_cnt | output | CNT_W | Differing bits counted |
| ac_cnt | output | NUM_LAGS*CNT_W | Packed per-lag agreement counts |
| wt_ok | output | 1 | Weight inside window |
| hd_ok | output | 1 | Distance inside window |
| ac_ok | output | NUM_LAGS | Per-lag agreement inside window |
| pass | output | 1 | Overall verdict |

## Verification
The assertions check on every cycle that the counts stay bounded by the bit count and the bit count by the region size, that idle cycles leave everything unchanged, that results appear after a last beat and hold until a new first beat, that compare sessions report no lag counts, and that pass never appears without valid full-region results and an in-window weight. Only the bench scenarios can show that the counts hold the right values: the weight of given patterns, the agreement of periodic patterns at chosen lags, the lag 0 and out-of-range lag edges, the distance for known flipped positions, and that a compare session leaves the stored reference intact.

// File: rtl/puf_stat_pkg.sv
package puf_stat_pkg;
  typedef enum logic {
    KIND_REF = 1'b0,
    KIND_CMP = 1'b1
  } sess_kind_e;
endpackage

// File: rtl/puf_ref_buffer.sv
module puf_ref_buffer #(
  parameter int REGION_BITS = 16384,
  parameter int WORD_W      = 32,
  parameter int NRD         = 3,
  localparam int IDX_W      = $clog2(REGION_BITS)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic                 wr_bit,
  input  logic [NRD*IDX_W-1:0] rd_idx,
  output logic [NRD-1:0]       rd_bit
);
  localparam int DEPTH = REGION_BITS / WORD_W;
  localparam int OFS_W = $clog2(WORD_W);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx[IDX_W-1:OFS_W]][wr_idx[OFS_W-1:0]] <= wr_bit;
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    logic [IDX_W-1:0] a;
    assign a         = rd_idx[k*IDX_W +: IDX_W];
    assign rd_bit[k] = mem[a[IDX_W-1:OFS_W]][a[OFS_W-1:0]];
  end
endmodule

// File: rtl/puf_lag_counter.sv
module puf_lag_counter #(
  parameter int CNT_W = 15,
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [CNT_W-1:0] lag,
  input  logic             bit_in,
  input  logic             ref_bit,
  output logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] idx_ext;
  logic             reach;
  logic             agree;
  logic [CNT_W-1:0] base;

  assign idx_ext = CNT_W'(cur_idx);
  assign reach   = idx_ext >= lag;
  assign rd_idx  = IDX_W'(idx_ext - lag);
  // a zero lag pairs each bit with itself
  assign agree   = (lag == '0) || (ref_bit == bit_in);
  assign base    = clear ? '0 : count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (clear || step)  count <= base + CNT_W'(step && reach && agree);
  end
endmodule

// File: rtl/puf_window.sv
module puf_window #(
  parameter int W = 15
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         ok
);
  assign ok = (value >= lo) && (value <= hi);
endmodule

// File: rtl/puf_stat_analyzer.sv
module puf_stat_analyzer
  import puf_stat_pkg::*;
#(
  parameter int REGION_BITS = 16384,
  parameter int WORD_W      = 32,
  parameter int NUM_LAGS    = 2,
  localparam int CNT_W      = $clog2(REGION_BITS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_bit,
  input  logic                    in_first,
  input  logic                    in_last,
  input  logic                    in_cmp,
  input  logic [NUM_LAGS*CNT_W-1:0] lag_cfg,
  input  logic [CNT_W-1:0]        wt_lo,
  input  logic [CNT_W-1:0]        wt_hi,
  input  logic [CNT_W-1:0]        hd_lo,
  input  logic [CNT_W-1:0]        hd_hi,
  input  logic [NUM_LAGS*CNT_W-1:0] ac_lo,
  input  logic [NUM_LAGS*CNT_W-1:0] ac_hi,
  output logic                    res_valid,
  output logic                    res_cmp,
  output logic [CNT_W-1:0]        bit_cnt,
  output logic [CNT_W-1:0]        weight_cnt,
  output logic [CNT_W-1:0]        hd_cnt,
  output logic [NUM_LAGS*CNT_W-1:0] ac_cnt,
  output logic                    wt_ok,
  output logic                    hd_ok,
  output logic [NUM_LAGS-1:0]     ac_ok,
  output logic                    pass
);
  localparam int IDX_W = $clog2(REGION_BITS);
  localparam int NRD   = NUM_LAGS + 1;
  localparam logic [CNT_W-1:0] REGION_C = CNT_W'(REGION_BITS);

  logic       ready_q;
  logic       active_q;
  logic       done_q;
  sess_kind_e kind_q;
  logic [CNT_W-1:0] cnt_q, wt_q, hd_q;

  logic       beat, start, live, room, take, ref_take, cmp_take;
  sess_kind_e kind_now;
  logic [IDX_W-1:0]     cur_idx;
  logic [NRD*IDX_W-1:0] rd_idx;
  logic [NRD-1:0]       rd_bit;

  // stream acceptance and session framing
  assign in_ready = ready_q;
  assign beat     = in_valid && ready_q;
  assign start    = beat && in_first;
  assign live     = start || (beat && active_q);
  assign room     = start || (cnt_q < REGION_C);
  assign take     = live && room;
  assign kind_now = start ? sess_kind_e'(in_cmp) : kind_q;
  assign ref_take = take && (kind_now == KIND_REF);
  assign cmp_take = take && (kind_now == KIND_CMP);
  assign cur_idx  = start ? '0 : cnt_q[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      kind_q   <= KIND_REF;
      cnt_q    <= '0;
      wt_q     <= '0;
      hd_q     <= '0;
    end else begin
      ready_q <= 1'b1;
      if (start) kind_q <= sess_kind_e'(in_cmp);
      if (live) begin
        active_q <= !in_last;
        done_q   <= in_last;
        cnt_q    <= (start ? '0 : cnt_q) + CNT_W'(take);
        wt_q     <= (start ? '0 : wt_q) + CNT_W'(take && in_bit);
        hd_q     <= (start ? '0 : hd_q) + CNT_W'(cmp_take && (in_bit != rd_bit[0]));
      end
    end
  end

  // reference storage: port 0 serves the compare pass, the rest the lags
  assign rd_idx[0 +: IDX_W] = cur_idx;

  puf_ref_buffer #(
    .REGION_BITS(REGION_BITS),
    .WORD_W     (WORD_W),
    .NRD        (NRD)
  ) u_buf (
    .clk   (clk),
    .wr_en (ref_take),
    .wr_idx(cur_idx),
    .wr_bit(in_bit),
    .rd_idx(rd_idx),
    .rd_bit(rd_bit)
  );

  for (genvar k = 0; k < NUM_LAGS; k++) begin : g_lag
    puf_lag_counter #(
      .CNT_W(CNT_W),
      .IDX_W(IDX_W)
    ) u_lag (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start),
      .step   (ref_take),
      .cur_idx(cur_idx),
      .lag    (lag_cfg[k*CNT_W +: CNT_W]),
      .bit_in (in_bit),
      .ref_bit(rd_bit[k+1]),
      .rd_idx (rd_idx[(k+1)*IDX_W +: IDX_W]),
      .count  (ac_cnt[k*CNT_W +: CNT_W])
    );

    puf_window #(.W(CNT_W)) u_ac_win (
      .value(ac_cnt[k*CNT_W +: CNT_W]),
      .lo   (ac_lo[k*CNT_W +: CNT_W]),
      .hi   (ac_hi[k*CNT_W +: CNT_W]),
      .ok   (ac_ok[k])
    );
  end

  puf_window #(.W(CNT_W)) u_wt_win (.value(wt_q), .lo(wt_lo), .hi(wt_hi), .ok(wt_ok));
  puf_window #(.W(CNT_W)) u_hd_win (.value(hd_q), .lo(hd_lo), .hi(hd_hi), .ok(hd_ok));

  assign res_valid  = done_q;
  assign res_cmp    = (kind_q == KIND_CMP);
  assign bit_cnt    = cnt_q;
  assign weight_cnt = wt_q;
  assign hd_cnt     = hd_q;
  assign pass = done_q && (cnt_q == REGION_C) && wt_ok &&
                ((kind_q == KIND_CMP) ? hd_ok : (&ac_ok));
endmodule

// File: rtl/puf_stat_analyzer_chk.sv
module puf_stat_analyzer_chk #(
  parameter int REGION_BITS = 16384,
  parameter int NUM_LAGS    = 2,
  localparam int CNT_W      = $clog2(REGION_BITS + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      in_first,
  input logic                      in_last,
  input logic                      active_q,
  input logic                      res_valid,
  input logic                      res_cmp,
  input logic [CNT_W-1:0]          bit_cnt,
  input logic [CNT_W-1:0]          weight_cnt,
  input logic [CNT_W-1:0]          hd_cnt,
  input logic [NUM_LAGS*CNT_W-1:0] ac_cnt,
  input logic                      wt_ok,
  input logic                      pass
);
  localparam logic [CNT_W-1:0] REGION_C = CNT_W'(REGION_BITS);

  assert_cnt_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= REGION_C);

  assert_weight_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    weight_cnt <= bit_cnt);

  assert_dist_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hd_cnt <= bit_cnt);

  assert_cmp_no_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_cmp) |-> (ac_cnt == '0));

  for (genvar k = 0; k < NUM_LAGS; k++) begin : g_chk
    assert_lag_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ac_cnt[k*CNT_W +: CNT_W] <= bit_cnt);
  end

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && (in_first || active_q)) |=> res_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !(in_valid && in_ready && in_first)) |=>
      (res_valid && $stable(bit_cnt) && $stable(weight_cnt) &&
       $stable(hd_cnt) && $stable(ac_cnt)));

  assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_first && !in_last) |=> (!res_valid && bit_cnt == CNT_W'(1)));

  assert_pass_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (res_valid && bit_cnt == REGION_C && wt_ok));

  assert_idle_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(bit_cnt) && $stable(weight_cnt) && $stable(res_valid)));
endmodule

bind puf_stat_analyzer puf_stat_analyzer_chk #(
  .REGION_BITS(REGION_BITS),
  .NUM_LAGS   (NUM_LAGS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_first  (in_first),
  .in_last   (in_last),
  .active_q  (active_q),
  .res_valid (res_valid),
  .res_cmp   (res_cmp),
  .bit_cnt   (bit_cnt),
  .weight_cnt(weight_cnt),
  .hd_cnt    (hd_cnt),
  .ac_cnt    (ac_cnt),
  .wt_ok     (wt_ok),
  .pass      (pass)
);

// File: tb/puf_stat_analyzer_tb.sv
`timescale 1ns/1ps
module puf_stat_analyzer_tb;
  localparam int RB    = 256;
  localparam int NL    = 2;
  localparam int CW    = $clog2(RB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_first = 1'b0, in_last = 1'b0, in_cmp = 1'b0;
  logic in_ready;
  logic [NL*CW-1:0] lag_cfg, ac_lo, ac_hi, ac_cnt;
  logic [CW-1:0] wt_lo, wt_hi, hd_lo, hd_hi;
  logic res_valid, res_cmp, wt_ok, hd_ok, pass;
  logic [CW-1:0] bit_cnt, weight_cnt, hd_cnt;
  logic [NL-1:0] ac_ok;

  int total = 0;
  int bad   = 0;
  logic pat  [0:511];
  logic refp [0:511];
  bit [31:0] seed = 32'h1234_5679;
  logic mid_valid;

  always #2 clk = ~clk;

  puf_stat_analyzer #(.REGION_BITS(RB), .WORD_W(32), .NUM_LAGS(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_first(in_first), .in_last(in_last), .in_cmp(in_cmp),
    .lag_cfg(lag_cfg), .wt_lo(wt_lo), .wt_hi(wt_hi), .hd_lo(hd_lo), .hd_hi(hd_hi),
    .ac_lo(ac_lo), .ac_hi(ac_hi), .res_valid(res_valid), .res_cmp(res_cmp),
    .bit_cnt(bit_cnt), .weight_cnt(weight_cnt), .hd_cnt(hd_cnt), .ac_cnt(ac_cnt),
    .wt_ok(wt_ok), .hd_ok(hd_ok), .ac_ok(ac_ok), .pass(pass)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic rnd_bit();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[3];
  endfunction

  task automatic fill_random();
    for (int i = 0; i < 512; i++) pat[i] = rnd_bit();
  endtask

  task automatic set_lags(input int l0, input int l1);
    lag_cfg = {CW'(l1), CW'(l0)};
  endtask

  task automatic open_windows();
    wt_lo = '0; wt_hi = CW'(RB);
    hd_lo = '0; hd_hi = CW'(RB);
    ac_lo = '0; ac_hi = {CW'(RB), CW'(RB)};
  endtask

  function automatic int ac_val(input int k);
    return int'(ac_cnt[k*CW +: CW]);
  endfunction

  function automatic int exp_weight(input int n);
    int c = 0;
    int m = (n > RB) ? RB : n;
    for (int i = 0; i < m; i++) c += int'(pat[i]);
    return c;
  endfunction

  function automatic int exp_ac(input int lag, input int n);
    int c = 0;
    int m = (n > RB) ? RB : n;
    for (int j = lag; j < m; j++) if (pat[j] == pat[j-lag]) c++;
    return c;
  endfunction

  function automatic int exp_hd(input int n);
    int c = 0;
    int m = (n > RB) ? RB : n;
    for (int i = 0; i < m; i++) if (pat[i] != refp[i]) c++;
    return c;
  endfunction

  // n beats from pat; optional idle gaps; close=0 leaves the session open
  task automatic send(input int n, input logic cmp, input bit gaps, input bit close);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 5 == 3)) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = pat[i];
      in_first = (i == 0);
      in_last  = close && (i == n - 1);
      in_cmp   = cmp;
      if (i == n - 1) mid_valid = res_valid;
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    if (!cmp) for (int i = 0; i < RB; i++) if (i < n) refp[i] = pat[i];
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 ready", int'(in_ready), 1);
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 pass", int'(pass), 0);
    chk("R1 bit_cnt", int'(bit_cnt), 0);
    chk("R1 weight", int'(weight_cnt), 0);
  endtask

  task automatic t_ref_random();
    int w;
    fill_random(); set_lags(16, 64); open_windows();
    send(RB, 1'b0, 1'b1, 1'b1);
    w = exp_weight(RB);
    chk("R6 valid low on last beat", int'(mid_valid), 0);
    chk("R6 valid after last", int'(res_valid), 1);
    chk("R5 bit_cnt full", int'(bit_cnt), RB);
    chk("R2 weight random", int'(weight_cnt), w);
    chk("R4 lag16 random", ac_val(0), exp_ac(16, RB));
    chk("R4 lag64 random", ac_val(1), exp_ac(64, RB));
    chk("R9 kind ref", int'(res_cmp), 0);
    chk("R8 pass wide windows", int'(pass), 1);
    wt_hi = CW'(w - 1);
    #1;
    chk("R7 wt above window", int'(wt_ok), 0);
    chk("R8 pass drops on weight", int'(pass), 0);
    wt_hi = CW'(w); wt_lo = CW'(w);
    #1;
    chk("R7 wt window inclusive", int'(wt_ok), 1);
    open_windows();
  endtask

  task automatic t_periodic();
    for (int i = 0; i < 512; i++) pat[i] = ((i % 16) < 8);
    set_lags(16, 64); open_windows();
    send(RB, 1'b0, 1'b0, 1'b1);
    chk("R2 weight periodic", int'(weight_cnt), 128);
    chk("R4 lag16 periodic", ac_val(0), 240);
    chk("R4 lag64 periodic", ac_val(1), 192);
    ac_hi = {CW'(RB), CW'(200)};
    #1;
    chk("R7 lag0 window exceeded", int'(ac_ok[0]), 0);
    chk("R7 lag1 window ok", int'(ac_ok[1]), 1);
    chk("R8 pass fails on lag", int'(pass), 0);
    open_windows();
  endtask

  task automatic t_lag_edges();
    fill_random(); set_lags(0, 300); open_windows();
    send(RB, 1'b0, 1'b0, 1'b1);
    chk("R4 lag zero counts all", ac_val(0), RB);
    chk("R4 lag beyond region", ac_val(1), 0);
  endtask

  task automatic t_compare();
    fill_random(); set_lags(16, 64); open_windows();
    send(RB, 1'b0, 1'b0, 1'b1);
    pat[0] = ~pat[0]; pat[5] = ~pat[5]; pat[100] = ~pat[100]; pat[255] = ~pat[255];
    hd_lo = '0; hd_hi = CW'(10);
    send(RB, 1'b1, 1'b1, 1'b1);
    chk("R3 distance four flips", int'(hd_cnt), exp_hd(RB));
    chk("R3 distance literal", int'(hd_cnt), 4);
    chk("R2 weight compare", int'(weight_cnt), exp_weight(RB));
    chk("R4 compare lag zero", ac_val(0) + ac_val(1), 0);
    chk("R9 kind cmp", int'(res_cmp), 1);
    chk("R8 pass compare", int'(pass), 1);
    hd_hi = CW'(3);
    #1;
    chk("R7 hd above window", int'(hd_ok), 0);
    chk("R8 pass drops on hd", int'(pass), 0);
    open_windows();
    pat[0] = ~pat[0]; pat[5] = ~pat[5]; pat[100] = ~pat[100]; pat[255] = ~pat[255];
    send(RB, 1'b1, 1'b0, 1'b1);
    chk("R3 reference kept", int'(hd_cnt), 0);
  endtask

  task automatic t_hold_ignore();
    int b = int'(bit_cnt);
    int w = int'(weight_cnt);
    int h = int'(hd_cnt);
    repeat (5) @(negedge clk);
    chk("R10 idle keeps weight", int'(weight_cnt), w);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_bit = 1'b1; in_first = 1'b0; in_last = (i == 3); in_cmp = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk("R5 stray beats bit_cnt", int'(bit_cnt), b);
    chk("R5 stray beats weight", int'(weight_cnt), w);
    chk("R6 held hd", int'(hd_cnt), h);
    chk("R6 valid held", int'(res_valid), 1);
  endtask

  task automatic t_overlong();
    fill_random(); set_lags(16, 64); open_windows();
    send(300, 1'b0, 1'b0, 1'b1);
    chk("R5 overlong capped", int'(bit_cnt), RB);
    chk("R5 overlong weight", int'(weight_cnt), exp_weight(300));
    chk("R5 overlong valid", int'(res_valid), 1);
    chk("R4 overlong lag16", ac_val(0), exp_ac(16, 300));
  endtask

  task automatic t_short();
    fill_random(); open_windows();
    send(100, 1'b0, 1'b0, 1'b1);
    chk("R5 short bit_cnt", int'(bit_cnt), 100);
    chk("R2 short weight", int'(weight_cnt), exp_weight(100));
    chk("R8 short no pass", int'(pass), 0);
  endtask

  task automatic t_restart();
    fill_random(); set_lags(16, 64); open_windows();
    for (int i = 0; i < 50; i++) pat[i] = 1'b1;
    send(50, 1'b0, 1'b0, 1'b0);
    chk("R6 open session not valid", int'(res_valid), 0);
    chk("R5 open session count", int'(bit_cnt), 50);
    fill_random();
    send(RB, 1'b0, 1'b0, 1'b1);
    chk("R5 restart bit_cnt", int'(bit_cnt), RB);
    chk("R5 restart weight", int'(weight_cnt), exp_weight(RB));
    chk("R4 restart lag64", ac_val(1), exp_ac(64, RB));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    set_lags(16, 64);
    open_windows();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ref_random();
    t_periodic();
    t_lag_edges();
    t_compare();
    t_hold_ignore();
    t_overlong();
    t_short();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule